// File: doc/BRIEF.md
# Branch Target Address Unit

This block works out where execution continues after a jump or a call in a segmented, real-mode style machine. On each request it takes the current code segment and instruction pointer, the byte length of the branch instruction and a kind code. Depending on the kind, it also uses a relative displacement, a far segment and offset pair, a register value, or a word that some other unit has already read from memory. One clock later it presents the new segment and pointer, and a flag that says whether the transfer left the current code segment.

Relative kinds measure their displacement from the address of the following instruction, which is the current pointer plus the instruction length. Pointer arithmetic stays within a 64 KiB segment and wraps modulo 2^16. The block does not fetch the memory word, does not push a return address and does not handle protection checks. It only forms the target.

Top module: `branch_target_unit`

## Requirements
- R1: A request accepted on a rising clock edge (`req_valid` high) produces its result, with `out_valid` high, after exactly one clock edge. `out_valid` is low in every cycle that does not follow a request.
- R2: Kind code 0 (short relative) gives `new_ip = cur_ip + instr_len + sign_extend(disp[7:0])` modulo 2^16, with a range of -128 to +127. Bits 15:8 of `disp` are ignored.
- R3: Kind code 1 (near relative) gives `new_ip = cur_ip + instr_len + disp` modulo 2^16, with `disp` treated as a signed 16-bit value. A result past FFFFh wraps to the bottom of the segment.
- R4: Kind code 2 (far direct) loads `new_cs = far_seg` and `new_ip = far_off`, and sets `cs_changed` to 1.
- R5: Kind code 3 (register indirect) gives `new_ip = reg_val`.
- R6: Kind code 4 (memory indirect) gives `new_ip = mem_word`.
- R7: For every kind code other than 2, `new_cs` equals the request's `cur_cs` and `cs_changed` is 0.
- R8: Kind codes 5, 6 and 7 are unsupported. They give the sequential address `new_ip = cur_ip + instr_len`.
- R9: After reset, `new_cs`, `new_ip` and `cs_changed` are 0. When no request arrives, all three hold their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| kind | input | 3 | Branch kind code |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Pointer of the branch instruction |
| instr_len | input | 4 | Byte length of the branch instruction |
| disp | input | 16 | Signed relative displacement |
| far_seg | input | 16 | Far target segment |
| far_off | input | 16 | Far target offset |
| reg_val | input | 16 | Register operand for the register-indirect kind |
| mem_word | input | 16 | Word read from memory for the memory-indirect kind |
| out_valid | output | 1 | Result valid |
| new_cs | output | 16 | Next code segment |
| new_ip | output | 16 | Next instruction pointer |
| cs_changed | output | 1 | Set when the transfer changed the segment |

## Verification
- **Short kind.** Displacements of +2, +127 and -128 are used, with junk in the upper byte of `disp`. This separates a correct 8-bit sign extension from a zero extension and from use of the full 16 bits.
- **Near kind.** One displacement crosses FFFFh forward and a negative one crosses zero backward. These show that the wrap is modulo 2^16 and that the instruction length is included in the sum.
- **Far, register, memory and unsupported kinds.** These run with distinct operand values in every input field, so that a wrong source selection or a stray segment change is visible.
- **Idle cycles.** Idle cycles with changing inputs confirm that the outputs hold their values.

// File: rtl/branch_target_unit.sv
module branch_target_unit #(
  parameter int W     = 16,
  parameter int LEN_W = 4,
  parameter int SD_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       kind,
  input  logic [W-1:0]     cur_cs,
  input  logic [W-1:0]     cur_ip,
  input  logic [LEN_W-1:0] instr_len,
  input  logic [W-1:0]     disp,
  input  logic [W-1:0]     far_seg,
  input  logic [W-1:0]     far_off,
  input  logic [W-1:0]     reg_val,
  input  logic [W-1:0]     mem_word,
  output logic             out_valid,
  output logic [W-1:0]     new_cs,
  output logic [W-1:0]     new_ip,
  output logic             cs_changed
);

  localparam logic [2:0] K_SHORT = 3'd0;
  localparam logic [2:0] K_NEAR  = 3'd1;
  localparam logic [2:0] K_FAR   = 3'd2;
  localparam logic [2:0] K_REG   = 3'd3;
  localparam logic [2:0] K_MEM   = 3'd4;

  logic [W-1:0] seq_ip;
  logic [W-1:0] short_off;
  logic [W-1:0] nxt_ip;
  logic [W-1:0] nxt_cs;
  logic         nxt_far;

  assign seq_ip    = cur_ip + {{(W-LEN_W){1'b0}}, instr_len};
  assign short_off = {{(W-SD_W){disp[SD_W-1]}}, disp[SD_W-1:0]};

  always_comb begin
    nxt_ip  = seq_ip;
    nxt_cs  = cur_cs;
    nxt_far = 1'b0;
    case (kind)
      K_SHORT: nxt_ip = seq_ip + short_off;
      K_NEAR:  nxt_ip = seq_ip + disp;
      K_FAR: begin
        nxt_ip  = far_off;
        nxt_cs  = far_seg;
        nxt_far = 1'b1;
      end
      K_REG:   nxt_ip = reg_val;
      K_MEM:   nxt_ip = mem_word;
      default: nxt_ip = seq_ip;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      new_cs     <= '0;
      new_ip     <= '0;
      cs_changed <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        new_cs     <= nxt_cs;
        new_ip     <= nxt_ip;
        cs_changed <= nxt_far;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);  // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);  // R1
  AST_FAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == K_FAR) |=> (cs_changed && new_cs == $past(far_seg) && new_ip == $past(far_off)));  // R4
  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == K_REG) |=> new_ip == $past(reg_val));  // R5
  AST_MEM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == K_MEM) |=> new_ip == $past(mem_word));  // R6
  AST_SEG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind != K_FAR) |=> (!cs_changed && new_cs == $past(cur_cs)));  // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(new_cs) && $stable(new_ip) && $stable(cs_changed)));  // R9

endmodule

// File: tb/branch_target_unit_tb.sv
module branch_target_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [15:0] cur_cs = '0, cur_ip = '0, disp = '0, far_seg = '0, far_off = '0;
  logic [15:0] reg_val = '0, mem_word = '0;
  logic [3:0]  instr_len = '0;
  logic        out_valid, cs_changed;
  logic [15:0] new_cs, new_ip;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  branch_target_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .instr_len(instr_len), .disp(disp),
    .far_seg(far_seg), .far_off(far_off), .reg_val(reg_val), .mem_word(mem_word),
    .out_valid(out_valid), .new_cs(new_cs), .new_ip(new_ip), .cs_changed(cs_changed)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [15:0] cs, input logic [15:0] ip,
                       input logic [3:0] len, input logic [15:0] d);
    @(negedge clk);
    kind = k; cur_cs = cs; cur_ip = ip; instr_len = len; disp = d;
    far_seg = 16'h5A5A; far_off = 16'hA5A5; reg_val = 16'h0F0F; mem_word = 16'hF0F0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 reset cs", new_cs, 16'h0);
    chk("R9 reset ip", new_ip, 16'h0);
    chk("R9 reset flag", {15'b0, cs_changed}, 16'h0);
    chk("R1 reset valid", {15'b0, out_valid}, 16'h0);
  endtask

  task automatic t_short;
    issue(3'd0, 16'h2000, 16'h0100, 4'd2, 16'h0002);
    chk("R2 skip two bytes", new_ip, 16'h0104);
    chk("R1 valid", {15'b0, out_valid}, 16'h1);
    @(negedge clk);
    chk("R1 valid drops", {15'b0, out_valid}, 16'h0);
    issue(3'd0, 16'h2000, 16'h0100, 4'd2, 16'hAB80);
    chk("R2 -128 upper ignored", new_ip, 16'h0082);
    chk("R7 short cs", new_cs, 16'h2000);
    issue(3'd0, 16'h2000, 16'h0100, 4'd2, 16'hFF7F);
    chk("R2 +127", new_ip, 16'h0181);
  endtask

  task automatic t_near;
    issue(3'd1, 16'h2100, 16'hFFF0, 4'd3, 16'h0020);
    chk("R3 forward wrap", new_ip, 16'h0013);
    chk("R7 near flag", {15'b0, cs_changed}, 16'h0);
    issue(3'd1, 16'h2100, 16'h0010, 4'd3, 16'hFF00);
    chk("R3 backward wrap", new_ip, 16'hFF13);
  endtask

  task automatic t_far;
    @(negedge clk);
    kind = 3'd2; cur_cs = 16'h2200; cur_ip = 16'h0040; instr_len = 4'd5; disp = 16'h1111;
    far_seg = 16'h1000; far_off = 16'h0000; reg_val = 16'h2222; mem_word = 16'h3333;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 far cs", new_cs, 16'h1000);
    chk("R4 far ip", new_ip, 16'h0000);
    chk("R4 far flag", {15'b0, cs_changed}, 16'h1);
  endtask

  task automatic t_indirect;
    @(negedge clk);
    kind = 3'd3; cur_cs = 16'h3000; cur_ip = 16'h0200; instr_len = 4'd2; disp = 16'h0044;
    reg_val = 16'h1234; mem_word = 16'h9999; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 reg ip", new_ip, 16'h1234);
    chk("R7 reg cs", new_cs, 16'h3000);
    chk("R7 reg flag", {15'b0, cs_changed}, 16'h0);
    @(negedge clk);
    kind = 3'd4; cur_cs = 16'h3100; reg_val = 16'h7777; mem_word = 16'hBEEF; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 mem ip", new_ip, 16'hBEEF);
    chk("R7 mem cs", new_cs, 16'h3100);
  endtask

  task automatic t_unsupported;
    for (int k = 5; k < 8; k++) begin
      issue(3'(k), 16'h4000, 16'h0300 + 16'(k), 4'd4, 16'h0100);
      chk("R8 sequential ip", new_ip, 16'h0304 + 16'(k));
      chk("R8 cs kept", new_cs, 16'h4000);
      chk("R8 flag clear", {15'b0, cs_changed}, 16'h0);
    end
  endtask

  task automatic t_hold;
    issue(3'd2, 16'h0000, 16'h0000, 4'd1, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      kind = 3'(i); cur_cs = 16'h6000 + 16'(i); cur_ip = 16'h1000 * 16'(i);
      far_seg = 16'h7777; far_off = 16'h8888; reg_val = 16'h4321; mem_word = 16'h1357;
      chk("R9 hold cs", new_cs, 16'h5A5A);
      chk("R9 hold ip", new_ip, 16'hA5A5);
      chk("R1 idle valid", {15'b0, out_valid}, 16'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_short();
    t_near();
    t_far();
    t_indirect();
    t_unsupported();
    t_hold();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule